// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider

This block turns a fast module clock into the two clocks an audio serial port needs: a master clock for the external converter and a bit clock for the serial data. Each clock comes from its own programmable divider, and neither divider uses a power-of-two table. The master divider picks one of eight ratios between 1 and 24. The bit divider then divides the master clock, not the module clock, by one of six even ratios.

Both divided clocks have a 50% duty cycle. If the control value changes or the enable drops, both dividers restart from a known low state, so no runt pulse reaches the pins. Along with the bit clock, the block gives two one-cycle strobes in the module-clock domain, one for each bit-clock edge. Downstream shift logic can use these strobes as clock enables and so stay entirely in the module-clock domain.

Software picks the divider codes: the master ratio sets the oversample factor (128 to 768 times the sample rate), and the bit ratio is that factor divided by twice the word size. There is no data stream, so all pins are plain control and clock signals.

Top module: `audio_clkgen`

## Requirements
- R1: `div_cfg` is decoded as follows: bit 7 is the master-clock enable, bits 6:4 are the bit-clock code, and bits 3:0 are the master-clock code.
- R2: While reset is asserted, all outputs are low. After reset the stored codes are zero, so nothing runs until the enable is set.
- R3: Master-clock codes 1 to 7 give module-clock ratios of 2, 4, 6, 8, 12, 16 and 24. The output is low for the first half-period after a restart and has a 50% duty cycle.
- R4: Master-clock code 0 (ratio 1) passes the module clock through to `mclk_o`. The gate opens two module-clock edges after the restart edge and closes only while the clock is low.
- R5: Master-clock codes 8 to 15 hold `mclk_o` and `bclk_o` low, and no strobes are raised.
- R6: Bit-clock codes 0 to 5 divide the master clock by 2, 4, 6, 8, 12 and 16. `bclk_o` changes only on module-clock edges where the master clock rises, and it starts low.
- R7: Bit-clock codes 6 and 7 hold `bclk_o` low and keep both strobes low.
- R8: While the enable bit is low, both clocks are held low, apart from the passthrough gate of R4, which closes half a cycle later.
- R9: A change in either code restarts both dividers on the first module-clock edge that sees the new value. On that edge `bclk_o` and the divided master clock go low without raising a strobe.
- R10: `bclk_rise_stb` is high for exactly the one module-clock cycle after `bclk_o` goes from 0 to 1, and `bclk_fall_stb` is high for exactly the one cycle after `bclk_o` goes from 1 to 0. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | 8 | Divider control value (enable, bit-clock code, master-clock code) |
| mclk_o | output | 1 | Master clock output |
| bclk_o | output | 1 | Bit clock output |
| bclk_rise_stb | output | 1 | One-cycle strobe after each bit-clock rising edge |
| bclk_fall_stb | output | 1 | One-cycle strobe after each bit-clock falling edge |

## Verification
The bench sweeps all eight master codes with the smallest bit ratio, so each master period length is measured on its own. It then sweeps all six bit codes over a fixed master ratio, which separates the two counters. A mixed pair, master ratio 6 with bit ratio 6, catches a bit counter that counts module cycles instead of master-clock rises. Invalid codes, a dropped enable and code changes made in the middle of a period show whether the restart and hold paths clear state without raising a stray strobe. The passthrough code shows whether the gate opens and closes on the right side of the clock.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int MCODE_W = 4;
  localparam int BCODE_W = 3;
  localparam int MAX_MRATIO = 24;
  localparam int MAX_BRATIO = 16;
  localparam int MCNT_W = $clog2(MAX_MRATIO / 2);
  localparam int BCNT_W = $clog2(MAX_BRATIO / 2);

  // master ratio per code, 0 marks an unused code
  function automatic int mclk_ratio(input logic [MCODE_W-1:0] code);
    case (code)
      4'd0: return 1;
      4'd1: return 2;
      4'd2: return 4;
      4'd3: return 6;
      4'd4: return 8;
      4'd5: return 12;
      4'd6: return 16;
      4'd7: return 24;
      default: return 0;
    endcase
  endfunction

  // bit-clock ratio relative to the master clock, 0 marks an unused code
  function automatic int bclk_ratio(input logic [BCODE_W-1:0] code);
    case (code)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 6;
      3'd3: return 8;
      3'd4: return 12;
      3'd5: return 16;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_cfg_track.sv
module clkdiv_cfg_track #(
  parameter int MCODE_W = 4,
  parameter int BCODE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [MCODE_W-1:0] mcode,
  input  logic [BCODE_W-1:0] bcode,
  output logic               restart
);
  logic [MCODE_W-1:0] mcode_q;
  logic [BCODE_W-1:0] bcode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcode_q <= '0;
      bcode_q <= '0;
    end else begin
      mcode_q <= mcode;
      bcode_q <= bcode;
    end
  end

  // any code change or a low enable pulls both dividers back to phase zero
  assign restart = !en || (mcode != mcode_q) || (bcode != bcode_q);
endmodule

// File: rtl/clkdiv_mclk.sv
module clkdiv_mclk
  import clkdiv_pkg::*;
#(
  parameter int CODE_W = MCODE_W,
  parameter int CNT_W  = MCNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              mclk_o,
  output logic              rise_tick
);
  int               ratio;
  logic             div_mode;
  logic             pass_mode;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] cnt;
  logic             mclk_q;
  logic             pass_p;
  logic             pass_n;

  always_comb begin
    ratio     = mclk_ratio(code);
    div_mode  = ratio >= 2;
    pass_mode = ratio == 1;
    last_cnt  = div_mode ? CNT_W'(ratio / 2 - 1) : '0;
  end

  assign rise_tick = !restart &&
                     (pass_mode || (div_mode && cnt == last_cnt && !mclk_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      mclk_q <= 1'b0;
    end else if (restart || !div_mode) begin
      cnt    <= '0;
      mclk_q <= 1'b0;
    end else if (cnt == last_cnt) begin
      cnt    <= '0;
      mclk_q <= !mclk_q;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pass_p <= 1'b0;
    else        pass_p <= !restart && pass_mode;
  end

  // gate enable retimed on the falling edge so it only moves while clk is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pass_n <= 1'b0;
    else        pass_n <= pass_p;
  end

  assign mclk_o = mclk_q | (clk & pass_n);
endmodule

// File: rtl/clkdiv_bclk.sv
module clkdiv_bclk
  import clkdiv_pkg::*;
#(
  parameter int CODE_W = BCODE_W,
  parameter int CNT_W  = BCNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              mclk_tick,
  input  logic [CODE_W-1:0] code,
  output logic              bclk_o,
  output logic              rise_stb,
  output logic              fall_stb
);
  int               ratio;
  logic             valid;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] cnt;
  logic             toggle;

  always_comb begin
    ratio    = bclk_ratio(code);
    valid    = ratio != 0;
    last_cnt = valid ? CNT_W'(ratio / 2 - 1) : '0;
    toggle   = mclk_tick && cnt == last_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      bclk_o   <= 1'b0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else if (restart || !valid) begin
      cnt      <= '0;
      bclk_o   <= 1'b0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      rise_stb <= toggle && !bclk_o;
      fall_stb <= toggle && bclk_o;
      if (toggle) begin
        cnt    <= '0;
        bclk_o <= !bclk_o;
      end else if (mclk_tick) begin
        cnt    <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import clkdiv_pkg::*;
#(
  parameter int EN_BIT    = 7,
  parameter int BCODE_LSB = 4,
  parameter int CFG_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] div_cfg,
  output logic             mclk_o,
  output logic             bclk_o,
  output logic             bclk_rise_stb,
  output logic             bclk_fall_stb
);
  logic               en;
  logic [MCODE_W-1:0] mcode;
  logic [BCODE_W-1:0] bcode;
  logic               restart;
  logic               mtick;

  assign en    = div_cfg[EN_BIT];
  assign mcode = div_cfg[MCODE_W-1:0];
  assign bcode = div_cfg[BCODE_LSB +: BCODE_W];

  clkdiv_cfg_track #(.MCODE_W(MCODE_W), .BCODE_W(BCODE_W)) u_track (
    .clk(clk), .rst_n(rst_n), .en(en), .mcode(mcode), .bcode(bcode),
    .restart(restart)
  );

  clkdiv_mclk #(.CODE_W(MCODE_W), .CNT_W(MCNT_W)) u_mdiv (
    .clk(clk), .rst_n(rst_n), .restart(restart), .code(mcode),
    .mclk_o(mclk_o), .rise_tick(mtick)
  );

  clkdiv_bclk #(.CODE_W(BCODE_W), .CNT_W(BCNT_W)) u_bdiv (
    .clk(clk), .rst_n(rst_n), .restart(restart), .mclk_tick(mtick),
    .code(bcode), .bclk_o(bclk_o), .rise_stb(bclk_rise_stb),
    .fall_stb(bclk_fall_stb)
  );
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] div_cfg,
  input logic       bclk_o,
  input logic       bclk_rise_stb,
  input logic       bclk_fall_stb
);
  a_r2_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!bclk_o && !bclk_rise_stb && !bclk_fall_stb));

  a_r8_enable_low_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !div_cfg[7] |=> (!bclk_o && !bclk_rise_stb && !bclk_fall_stb));

  a_r7_unused_code_low: assert property (@(posedge clk) disable iff (!rst_n)
    (div_cfg[6:4] >= 3'd6) |=> !bclk_o);

  a_r5_unused_mcode_low: assert property (@(posedge clk) disable iff (!rst_n)
    (div_cfg[3:0] >= 4'd8) |=> (!bclk_o && !bclk_rise_stb));

  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bclk_rise_stb && bclk_fall_stb));

  a_r10_rise_matches_edge: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise_stb |-> (bclk_o && !$past(bclk_o)));

  a_r10_fall_matches_edge: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_fall_stb |-> (!bclk_o && $past(bclk_o)));
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .bclk_o(bclk_o),
  .bclk_rise_stb(bclk_rise_stb), .bclk_fall_stb(bclk_fall_stb)
);

// File: tb/audio_clkgen_test.sv
`timescale 1ns/1ps
module audio_clkgen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_cfg = 8'h00;
  logic       mclk_o, bclk_o, bclk_rise_stb, bclk_fall_stb;

  int    vectors = 0;
  int    miscompares = 0;
  string req = "R2";
  bit    finished = 1'b0;

  // reference ratio tables, written from the requirements
  int mr[8] = '{1, 2, 4, 6, 8, 12, 16, 24};
  int br[6] = '{2, 4, 6, 8, 12, 16};

  // reference model state
  int k = 0;
  int prev_mc = 0, prev_bc = 0;
  bit pass_p = 0, pass_n = 0, last_b = 0;

  always #4 clk = !clk;

  audio_clkgen uut (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .mclk_o(mclk_o),
    .bclk_o(bclk_o), .bclk_rise_stb(bclk_rise_stb), .bclk_fall_stb(bclk_fall_stb)
  );

  always @(posedge clk) begin
    int mc, bc, rm, rb, divm, rises, t;
    bit en, eb, em, er, ef;
    mc = int'(div_cfg[3:0]);
    bc = int'(div_cfg[6:4]);
    en = div_cfg[7];
    if (!rst_n || !en || mc != prev_mc || bc != prev_bc) k = 0;
    else k++;
    prev_mc = rst_n ? mc : 0;
    prev_bc = rst_n ? bc : 0;
    pass_n = pass_p;
    pass_p = rst_n && k >= 1 && mc == 0;
    rm = (mc < 8) ? mr[mc] : 0;
    rb = (bc < 6) ? br[bc] : 0;
    divm = 0; rises = 0;
    if (rm == 1) rises = k;
    else if (rm >= 2) begin
      t = k / (rm / 2);
      divm = t % 2;
      rises = (t + 1) / 2;
    end
    eb = (rb == 0) ? 1'b0 : (((rises / (rb / 2)) % 2) == 1);
    er = eb && !last_b && k != 0;
    ef = !eb && last_b && k != 0;
    last_b = eb;
    em = (divm == 1) || pass_n;
    #2;
    vectors++;
    if (mclk_o !== em || bclk_o !== eb || bclk_rise_stb !== er || bclk_fall_stb !== ef) begin
      miscompares++;
      $display("FAIL %s cfg=%h k=%0d got mclk=%b bclk=%b rise=%b fall=%b exp mclk=%b bclk=%b rise=%b fall=%b",
               req, div_cfg, k, mclk_o, bclk_o, bclk_rise_stb, bclk_fall_stb, em, eb, er, ef);
    end
  end

  task automatic run(input logic [7:0] cfg, input int n, input string tag);
    @(negedge clk);
    div_cfg = cfg;
    req = tag;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired during %s", req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R2: reset state, then one enabled config held during reset
    repeat (4) @(negedge clk);
    div_cfg = 8'h81;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(8'h00, 20, "R8");
    // R3 and R4: every master code with the smallest bit ratio
    for (int c = 0; c < 8; c++)
      run(8'h80 | 8'(c), mr[c] * 16 + 6, (c == 0) ? "R4" : "R3");
    // R6: every bit code over master ratio 2
    for (int c = 0; c < 6; c++)
      run(8'h81 | 8'(c << 4), br[c] * 12 + 6, "R6");
    run(8'hA3, 200, "R1");
    run(8'h89, 40, "R5");
    run(8'h8F, 40, "R5");
    run(8'hE1, 40, "R7");
    run(8'hF0, 40, "R7");
    // R9: code changes in the middle of a period
    run(8'h92, 37, "R9");
    run(8'h94, 23, "R9");
    run(8'h80, 9, "R9");
    run(8'h93, 150, "R10");
    run(8'h13, 20, "R8");
    run(8'h80, 10, "R4");
    run(8'h00, 10, "R8");
    run(8'hB7, 900, "R10");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule